// File: doc/BRIEF.md
# Palette-Indexed Pixel Output Pipeline

This block turns bytes fetched from video memory into per-pixel colour without a shift register. On every pixel slot it forms a palette address from the current data byte, the column bits of the slot and a software palette select, reads an 8-bit colour from an internal palette RAM, and registers it onto the colour output. Each colour word packs 3 bits of green, 3 bits of red and 2 bits of blue. The bit depth is never selected in hardware. Software picks 1, 2, 4 or 8 bits per pixel only by what it writes into the palette, because the column bits are part of the lookup address.

The block also generates the byte fetch address. A line base advances by 64 bytes for each displayed line. Within the visible part of a line, a byte index counts up to 39. In text mode a new byte is taken every 8 slots. In graphics mode a new byte is taken every 4 slots, and the column bits step by two so that the palette still sees column values 0 to 7 across the byte. A CPU port writes palette entries at any time. Video memory and the digital-to-analog stage are outside the block: they appear as a byte input and a colour output.

With its default parameters the palette select is one bit wide, which keeps the elaborated RAM at 4096 entries. With four select bits, the lookup address reaches its full 15 bits.

Top module: `pixel_palette_out`

## Requirements
- R1: While reset is asserted, and afterwards until the first visible slot, `rgb_out` is 0 and `fetch_addr` is 0.
- R2: For a visible slot, `rgb_out` two clock cycles later equals the palette entry at address {select, byte, column}: the select in the top bits, then the 8-bit byte, then the 3 column bits at the bottom.
- R3: In text mode (`text_mode`=1), slot s of a visible run uses column s mod 8. The byte it uses is the one fetched at slot 8*floor(s/8).
- R4: In graphics mode (`text_mode`=0), slot s uses column 2*(s mod 4). The byte it uses is the one fetched at slot 4*floor(s/4).
- R5: `rgb_out` is 0 two cycles after any slot in which `hblank` or `vblank` is high.
- R6: During a visible slot, `fetch_addr` equals line base + min(byte index, 39). The byte index is floor(s/8) in text mode and floor(s/4) in graphics mode. While blanked, `fetch_addr` equals the line base.
- R7: The line base grows by 64 after each visible run that ends while `vblank` is low. It is set to 0 whenever `vblank` is high.
- R8: A palette write takes effect at the clock edge where `cpu_we` is sampled high. A display read at that same edge returns the old entry, and reads at later edges return the new entry.
- R9: `pal_sel` is sampled on every slot, so changing it between adjacent slots switches palettes for each pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank | input | 1 | Horizontal blanking, high outside the visible part of a line |
| vblank | input | 1 | Vertical blanking |
| text_mode | input | 1 | 1: byte every 8 slots; 0: byte every 4 slots |
| pal_sel | input | SEL_W (1) | Palette select, top address bits |
| fetch_data | input | 8 | Byte returned by video memory for `fetch_addr` in the same cycle |
| fetch_addr | output | 14 | Video memory byte address |
| cpu_we | input | 1 | Palette write strobe |
| cpu_addr | input | SEL_W+11 (12) | Palette write address {select, byte, column} |
| cpu_wdata | input | 8 | Palette colour word (GGG RRR BB) |
| rgb_out | output | 8 | Registered pixel colour |

## Verification
A wrong slot counter, a column mapping error or a stale byte register shows on `rgb_out` two cycles after the faulty slot, as a colour that belongs to a neighbouring pixel or palette. A bad byte index or line base shows up at once on `fetch_addr`, and also two cycles later as colours read for the wrong byte. Broken write-versus-read ordering changes exactly one pixel, the one whose read shares an edge with the write. Blanking faults show as non-zero colour during the two-cycle tail after a visible run.

// File: rtl/pixel_palette_out.sv
module pixel_palette_out #(
  parameter int BYTE_W      = 8,
  parameter int COL_W       = 3,
  parameter int SEL_W       = 1,
  parameter int COLOR_W     = 8,
  parameter int VIS_BYTES   = 40,
  parameter int LINE_STRIDE = 64,
  parameter int LINES       = 240,
  localparam int PA_W   = SEL_W + BYTE_W + COL_W,
  localparam int VA_W   = $clog2(LINES * LINE_STRIDE),
  localparam int SLOT_W = $clog2(VIS_BYTES << COL_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hblank,
  input  logic               vblank,
  input  logic               text_mode,
  input  logic [SEL_W-1:0]   pal_sel,
  input  logic [BYTE_W-1:0]  fetch_data,
  output logic [VA_W-1:0]    fetch_addr,
  input  logic               cpu_we,
  input  logic [PA_W-1:0]    cpu_addr,
  input  logic [COLOR_W-1:0] cpu_wdata,
  output logic [COLOR_W-1:0] rgb_out
);
  localparam int DEPTH = 1 << PA_W;
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(VIS_BYTES - 1);

  logic [COLOR_W-1:0] pal [DEPTH];
  logic [COLOR_W-1:0] rd_q;
  logic [SLOT_W-1:0]  slot, idx_raw, idx;
  logic [VA_W-1:0]    line_base;
  logic [BYTE_W-1:0]  byte_q;
  logic [COL_W-1:0]   col_now, col_q;
  logic [SEL_W-1:0]   sel_q;
  logic               vis, vis_d1, vis_d2, load;

  assign vis     = !hblank && !vblank;
  assign col_now = text_mode ? slot[COL_W-1:0] : {slot[COL_W-2:0], 1'b0};
  assign load    = vis && (col_now == '0);
  assign idx_raw = text_mode ? (slot >> COL_W) : (slot >> (COL_W - 1));
  assign idx     = !vis ? '0 : (idx_raw > LAST_IDX) ? LAST_IDX : idx_raw;
  assign fetch_addr = line_base + VA_W'(idx);

  always_ff @(posedge clk) begin
    if (!rst_n)          slot <= '0;
    else if (!vis)       slot <= '0;
    else if (slot != '1) slot <= slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || vblank)     line_base <= '0;
    else if (vis_d1 && !vis)  line_base <= line_base + VA_W'(LINE_STRIDE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      col_q  <= '0;
      sel_q  <= '0;
      vis_d1 <= 1'b0;
      vis_d2 <= 1'b0;
    end else begin
      if (load) byte_q <= fetch_data;
      col_q  <= col_now;
      sel_q  <= pal_sel;
      vis_d1 <= vis;
      vis_d2 <= vis_d1;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_we) pal[cpu_addr] <= cpu_wdata;
    rd_q <= pal[{sel_q, byte_q, col_q}];
  end

  assign rgb_out = vis_d2 ? rd_q : '0;

  a_r5_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank || vblank) |-> ##2 (rgb_out == '0));

  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr - line_base) < VA_W'(VIS_BYTES));

  a_r7_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_d1 && !vis && !vblank) |=> (line_base == $past(line_base) + VA_W'(LINE_STRIDE)));

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> (pal[$past(cpu_addr)] == $past(cpu_wdata)));

  a_r4_col_even: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && !text_mode) |=> (col_q[0] == 1'b0));
endmodule

// File: tb/pixel_palette_out_test.sv
module pixel_palette_out_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hblank = 1'b1, vblank = 1'b1, text_mode = 1'b1;
  logic [0:0]  pal_sel = '0;
  logic [7:0]  fetch_data;
  logic [13:0] fetch_addr;
  logic        cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rgb_out;
  logic        flat = 1'b0;

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] pm [4096];

  int base = 0, nbase = 0;
  bit upd = 0, pvis = 0;
  bit pv1 = 0, pv2 = 0;
  int e1 = 0, e2 = 0;
  string t1 = "", t2 = "";

  always #4 clk = ~clk;

  pixel_palette_out uut (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank),
    .text_mode(text_mode), .pal_sel(pal_sel), .fetch_data(fetch_data),
    .fetch_addr(fetch_addr), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .rgb_out(rgb_out)
  );

  function automatic logic [7:0] vm(input int a, input bit f);
    return f ? 8'h00 : 8'((a * 29) ^ (a >> 6));
  endfunction

  assign fetch_data = vm(int'(fetch_addr), flat);

  function automatic logic [7:0] pinit(input int a);
    int s, d, c, p;
    s = a / 2048; d = (a / 8) % 256; c = a % 8;
    if (s == 0) return ((d >> c) & 1) != 0 ? 8'hFF : 8'h00;
    p = (d >> ((c / 2) * 2)) & 3;
    case (p)
      0: return 8'h00;
      1: return 8'h07;
      2: return 8'h38;
      default: return 8'hC0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_line(input bit mode, input bit sel, input bit tog, input bit vb,
                          input int n, input int wslot, input int waddr,
                          input int wdata, input string tag);
    for (int s = 0; s < n + 8; s++) begin
      bit vis;
      int idx, col, sl, by, ea;
      @(negedge clk);
      if (pv2) chk(rgb_out == e2[7:0], t2, rgb_out, e2);
      pv2 = pv1; e2 = e1; t2 = t1;
      if (upd) begin base = nbase; upd = 0; end
      vis = (s < n) && !vb;
      hblank = !(s < n);
      vblank = vb;
      text_mode = mode;
      sl = sel ^ (tog & s[0]);
      pal_sel = sl[0:0];
      if (s == wslot) begin
        cpu_we = 1'b1; cpu_addr = 12'(waddr); cpu_wdata = 8'(wdata);
        pm[waddr] = 8'(wdata);
      end else cpu_we = 1'b0;
      idx = mode ? s / 8 : s / 4;
      if (idx > 39) idx = 39;
      col = mode ? s % 8 : (s % 4) * 2;
      by = vm(base + idx, flat);
      e1 = vis ? int'(pm[sl * 2048 + by * 8 + col]) : 0;
      t1 = vis ? tag : "R5";
      pv1 = 1;
      ea = base + (vis ? idx : 0);
      #1 chk(fetch_addr == 14'(ea), "R6", fetch_addr, ea);
      if (vb) begin upd = 1; nbase = 0; end
      else if (pvis && !vis) begin upd = 1; nbase = base + 64; end
      pvis = vis;
    end
    cpu_we = 1'b0;
  endtask

  // mode, sel, toggle, vblank, slots
  localparam logic [13:0] ROWS [7] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 10'd320},
    {1'b0, 1'b1, 1'b0, 1'b0, 10'd160},
    {1'b1, 1'b1, 1'b1, 1'b0, 10'd64},
    {1'b0, 1'b0, 1'b0, 1'b0, 10'd200},
    {1'b1, 1'b0, 1'b0, 1'b0, 10'd336},
    {1'b1, 1'b0, 1'b0, 1'b1, 10'd20},
    {1'b1, 1'b0, 1'b0, 1'b0, 10'd8}
  };

  function automatic string row_tag(input int r);
    case (r)
      0: return "R2";
      1: return "R4";
      2: return "R9";
      3: return "R6";
      4: return "R3";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(rgb_out == 8'h00, "R1", rgb_out, 0);
    chk(fetch_addr == 14'h0, "R1", fetch_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rgb_out == 8'h00, "R1", rgb_out, 0);
    chk(fetch_addr == 14'h0, "R1", fetch_addr, 0);

    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = 12'(a); pm[a] = pinit(a); cpu_wdata = pm[a];
    end
    @(negedge clk);
    cpu_we = 1'b0;
    chk(rgb_out == 8'h00, "R1", rgb_out, 0);
    @(negedge clk);
    vblank = 1'b0;

    for (int r = 0; r < 7; r++) begin
      logic [13:0] v;
      v = ROWS[r];
      run_line(v[13], v[12], v[11], v[10], int'(v[9:0]), -1, 0, 0, row_tag(r));
    end

    flat = 1'b1;
    run_line(1'b1, 1'b0, 1'b0, 1'b0, 40, 12, 3, 8'h5A, "R8");
    run_line(1'b1, 1'b0, 1'b0, 1'b0, 0, -1, 0, 0, "R5");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule